// File: doc/BRIEF.md
# DDR Input Capture Register Stage

This block conditions an input data bit on its way from a pad into core logic. In single-data-rate mode the bit is registered on the rising edge of the system clock. In double-data-rate mode it is sampled on both edges of a source-synchronous strobe. The rising-edge sample is retimed onto the falling strobe edge, so the two samples form one aligned pair. That pair is then moved into the system clock domain as a unit.

A runtime polarity input picks which system clock edge loads the resynchronization registers. This lets the integrator trade setup against hold margin on the strobe-to-clock crossing. Two bypass outputs carry the unregistered pin value, one for use as data and one for use as a clock. An input delay option is accepted as a configuration bit and modelled as a zero-delay path. The data width is a parameter and defaults to one bit.

Top module: `ddr_in_capture`

## Requirements
- R1: While `rst` is high across successive system clock edges of both polarities, `q0` and `q2` read 0. Reset is synchronous to the clock of each register.
- R2: With `mode_ddr`=0 and `ce`=1, `q0` equals `din` as sampled at the latest rising `clk` edge, and `q2` reads 0. `clk_pol` has no effect in this mode.
- R3: With `mode_ddr`=1, each pair appears together on the outputs: `q0` carries the bit sampled at a rising `strb` edge and `q2` the bit sampled at the following falling `strb` edge.
- R4: With `clk_pol`=0 the pair is loaded into the output registers on the rising `clk` edge. With `clk_pol`=1 it is loaded on the falling `clk` edge.
- R5: While `ce` is low, the single-data-rate register and the resynchronization registers keep their values, so `q0` and `q2` do not change.
- R6: `raw_data` and `raw_clk` both equal `din` combinationally, in either mode.
- R7: `dly_en` has no functional effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| strb | input | 1 | Source-synchronous data strobe |
| rst | input | 1 | Active-high reset, synchronous in each clock domain |
| ce | input | 1 | Clock enable for the single-data-rate and resynchronization registers |
| mode_ddr | input | 1 | 0 selects single-data-rate mode, 1 selects double-data-rate mode |
| clk_pol | input | 1 | 0: resynchronize on the rising clk edge; 1: on the falling clk edge |
| dly_en | input | 1 | Input delay option (zero-delay model) |
| din | input | DW | Data from the input buffer |
| q0 | output | DW | Rising-strobe sample (DDR) or registered bit (SDR) |
| q2 | output | DW | Falling-strobe sample (DDR), 0 in SDR |
| raw_data | output | DW | Unregistered data bypass |
| raw_clk | output | DW | Unregistered bypass for use as a clock |

## Verification
The strobe runs at the clock frequency with a fixed quarter-period lead. A table of rise/fall bit pairs is driven through it, including equal pairs, opposite pairs and repeated pairs, so that a swapped or duplicated `q0`/`q2` stream cannot pass. Each pair is sampled at two points in the clock period. The late sample confirms pair integrity under both polarities. The early sample falls between the falling and rising clock edges and so tells which edge loaded the pair. Directed sequences cover hold under a low enable, reset in the middle of traffic, single-data-rate capture with alternating bits, and bypass levels.

// File: rtl/ddr_in_pkg.sv
package ddr_in_pkg;

    typedef enum logic {
        CAP_SDR = 1'b0,
        CAP_DDR = 1'b1
    } cap_mode_e;

    // number of system clock edges available to the resync stage
    localparam int unsigned SYS_EDGES = 2;

endpackage

// File: rtl/ddr_strobe_capture.sv
// Samples din on both strobe edges and retimes the rising sample onto the
// falling edge so that both halves of a pair change together.
module ddr_strobe_capture #(
    parameter int DW = 1
) (
    input  logic          strb,
    input  logic          rst,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] pair_rise,
    output logic [DW-1:0] pair_fall
);

    typedef struct packed {
        logic [DW-1:0] rise;
    } pos_st_t;

    typedef struct packed {
        logic [DW-1:0] rise_ret;
        logic [DW-1:0] fall;
    } neg_st_t;

    pos_st_t pos_d, pos_q;
    neg_st_t neg_d, neg_q;

    always_comb begin
        pos_d = pos_q;
        if (rst) begin
            pos_d.rise = '0;
        end else begin
            pos_d.rise = din;
        end
    end

    always_comb begin
        neg_d = neg_q;
        if (rst) begin
            neg_d.rise_ret = '0;
            neg_d.fall     = '0;
        end else begin
            neg_d.rise_ret = pos_q.rise;
            neg_d.fall     = din;
        end
    end

    always_ff @(posedge strb) begin
        pos_q <= pos_d;
    end

    always_ff @(negedge strb) begin
        neg_q <= neg_d;
    end

    assign pair_rise = neg_q.rise_ret;
    assign pair_fall = neg_q.fall;

    // R3: the retimed half of a pair is the sample taken at the preceding rising edge
    a_r3_rise_retimed: assert property (@(negedge strb) disable iff (rst)
        1'b1 |=> (pair_rise == $past(pos_q.rise)));

endmodule

// File: rtl/ddr_sys_resync.sv
// Moves an aligned strobe-domain pair into the system clock domain. One
// register bank per clock edge; clk_pol picks the bank that drives the outputs.
module ddr_sys_resync #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          clk_pol,
    input  logic [DW-1:0] pair_rise,
    input  logic [DW-1:0] pair_fall,
    output logic [DW-1:0] sync_rise,
    output logic [DW-1:0] sync_fall
);
    import ddr_in_pkg::*;

    typedef struct packed {
        logic [DW-1:0] rise;
        logic [DW-1:0] fall;
    } bank_st_t;

    logic [SYS_EDGES-1:0][DW-1:0] bank_rise;
    logic [SYS_EDGES-1:0][DW-1:0] bank_fall;

    for (genvar e = 0; e < SYS_EDGES; e++) begin : g_bank
        logic     bclk;
        bank_st_t bk_d, bk_q;

        // edge 0 uses the true clock, edge 1 the inverted clock
        assign bclk = (e == 0) ? clk : ~clk;

        always_comb begin
            bk_d = bk_q;
            if (rst) begin
                bk_d.rise = '0;
                bk_d.fall = '0;
            end else if (ce) begin
                bk_d.rise = pair_rise;
                bk_d.fall = pair_fall;
            end
        end

        always_ff @(posedge bclk) begin
            bk_q <= bk_d;
        end

        assign bank_rise[e] = bk_q.rise;
        assign bank_fall[e] = bk_q.fall;

        // R5: a low enable freezes the bank
        a_r5_bank_hold: assert property (@(posedge bclk) disable iff (rst)
            !ce |=> ($stable(bk_q.rise) && $stable(bk_q.fall)));

        // R4: an enabled edge of this bank loads the pair presented at that edge
        a_r4_bank_load: assert property (@(posedge bclk) disable iff (rst)
            ce |=> ((bk_q.rise == $past(pair_rise)) && (bk_q.fall == $past(pair_fall))));
    end

    always_comb begin
        sync_rise = clk_pol ? bank_rise[1] : bank_rise[0];
        sync_fall = clk_pol ? bank_fall[1] : bank_fall[0];
    end

endmodule

// File: rtl/ddr_sdr_reg.sv
// Single-data-rate capture register on the rising system clock edge.
module ddr_sdr_reg #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sdr_q
);

    typedef struct packed {
        logic [DW-1:0] data;
    } sdr_st_t;

    sdr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.data = '0;
        end else if (ce) begin
            st_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sdr_q = st_q.data;

    // R2: an enabled edge captures the input bit
    a_r2_sdr_capture: assert property (@(posedge clk) disable iff (rst)
        ce |=> (sdr_q == $past(din)));

    // R5: a low enable holds the register
    a_r5_sdr_hold: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(sdr_q));

    // R1: reset clears the register at the next edge
    a_r1_sdr_clear: assert property (@(posedge clk)
        rst |=> (sdr_q == '0));

endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          strb,
    input  logic          rst,
    input  logic          ce,
    input  logic          mode_ddr,
    input  logic          clk_pol,
    input  logic          dly_en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] q0,
    output logic [DW-1:0] q2,
    output logic [DW-1:0] raw_data,
    output logic [DW-1:0] raw_clk
);
    import ddr_in_pkg::*;

    cap_mode_e     mode_e;
    logic [DW-1:0] din_dly;
    logic [DW-1:0] cond_din;
    logic [DW-1:0] pair_rise;
    logic [DW-1:0] pair_fall;
    logic [DW-1:0] sync_rise;
    logic [DW-1:0] sync_fall;
    logic [DW-1:0] sdr_q;

    assign mode_e = cap_mode_e'(mode_ddr);

    // delay element modelled as a zero-delay path
    assign din_dly  = din;
    assign cond_din = dly_en ? din_dly : din;

    assign raw_data = din;
    assign raw_clk  = din;

    ddr_strobe_capture #(.DW(DW)) u_cap (
        .strb      (strb),
        .rst       (rst),
        .din       (cond_din),
        .pair_rise (pair_rise),
        .pair_fall (pair_fall)
    );

    ddr_sys_resync #(.DW(DW)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .clk_pol   (clk_pol),
        .pair_rise (pair_rise),
        .pair_fall (pair_fall),
        .sync_rise (sync_rise),
        .sync_fall (sync_fall)
    );

    ddr_sdr_reg #(.DW(DW)) u_sdr (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .din   (cond_din),
        .sdr_q (sdr_q)
    );

    always_comb begin
        if (mode_e == CAP_DDR) begin
            q0 = sync_rise;
            q2 = sync_fall;
        end else begin
            q0 = sdr_q;
            q2 = '0;
        end
    end

    // R1: reset held over a full clock period clears both outputs
    a_r1_out_clear: assert property (@(posedge clk)
        (rst && $past(rst)) |-> ((q0 == '0) && (q2 == '0)));

endmodule

// File: tb/ddr_in_capture_tb_top.sv
module ddr_in_capture_tb_top;

    localparam int NV = 12;
    // bit 1: value driven for the rising strobe edge, bit 0: for the falling edge
    localparam logic [1:0] VEC [NV] = '{
        2'b10, 2'b01, 2'b11, 2'b00, 2'b10, 2'b10,
        2'b01, 2'b01, 2'b11, 2'b01, 2'b00, 2'b10
    };

    logic clk = 1'b0;
    logic strb = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b1;
    logic mode_ddr = 1'b1;
    logic clk_pol = 1'b0;
    logic dly_en = 1'b0;
    logic [0:0] din = 1'b0;
    logic [0:0] q0, q2, raw_data, raw_clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // 125 MHz: rising clk at 8k+4, rising strobe at 8k+2
    always #4 clk = ~clk;
    initial begin
        #2;
        forever begin
            strb = 1'b1;
            #4;
            strb = 1'b0;
            #4;
        end
    end

    ddr_in_capture #(.DW(1)) dut_i (
        .clk      (clk),
        .strb     (strb),
        .rst      (rst),
        .ce       (ce),
        .mode_ddr (mode_ddr),
        .clk_pol  (clk_pol),
        .dly_en   (dly_en),
        .din      (din),
        .q0       (q0),
        .q2       (q2),
        .raw_data (raw_data),
        .raw_clk  (raw_clk)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] vec_at(input int i);
        return (i >= 0 && i < NV) ? VEC[i] : 2'b00;
    endfunction

    // move to offset 0 of a period (a time of the form 8k)
    task automatic align();
        @(posedge clk);
        #4;
    endtask

    // one period starting at offset 0: rise bit at +1, fall bit at +5
    task automatic tick_pair(input logic a, input logic b);
        #1 din = a;
        #4 din = b;
        #3;
    endtask

    // walk the table; offset 7 sees pair j-1 for either polarity (R3),
    // offset 1 sees pair j-1 with falling-edge transfer, j-2 with rising (R4)
    task automatic run_table(input logic pol, input logic dly);
        align();
        clk_pol = pol;
        dly_en  = dly;
        for (int j = 0; j < NV + 2; j++) begin
            logic [1:0] v;
            logic [1:0] e1;
            logic [1:0] e7;
            v = vec_at(j);
            #1;
            if (j >= 2) begin
                e1 = pol ? vec_at(j - 1) : vec_at(j - 2);
                check(dly ? "R4/R7 early q0" : "R4 early q0", q0[0], e1[1]);
                check(dly ? "R4/R7 early q2" : "R4 early q2", q2[0], e1[0]);
            end
            din = v[1];
            #4 din = v[0];
            #2;
            if (j >= 1) begin
                e7 = vec_at(j - 1);
                check(dly ? "R3/R7 q0" : "R3 q0", q0[0], e7[1]);
                check(dly ? "R3/R7 q2" : "R3 q2", q2[0], e7[0]);
            end
            #1;
        end
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R1: reset state with data moving and the falling-edge bank selected
        clk_pol = 1'b1;
        din = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check("R1 q0 reset", q0[0], 1'b0);
        check("R1 q2 reset", q2[0], 1'b0);
        align();
        #1 rst = 1'b0;
        #7;

        // R3 / R4 with both polarities, R7 with the delay option set
        run_table(1'b0, 1'b0);
        run_table(1'b1, 1'b0);
        run_table(1'b0, 1'b1);
        run_table(1'b1, 1'b1);

        // R5: DDR hold while the enable is low
        align();
        clk_pol = 1'b0;
        dly_en  = 1'b0;
        tick_pair(1'b1, 1'b1);
        tick_pair(1'b1, 1'b1);
        tick_pair(1'b1, 1'b1);
        #1 ce = 1'b0;
        din = 1'b0;
        #6;
        check("R5 ddr q0 hold", q0[0], 1'b1);
        check("R5 ddr q2 hold", q2[0], 1'b1);
        #1;
        tick_pair(1'b0, 1'b0);
        tick_pair(1'b0, 1'b0);
        #7;
        check("R5 ddr q0 hold late", q0[0], 1'b1);
        check("R5 ddr q2 hold late", q2[0], 1'b1);
        #1 ce = 1'b1;
        #7;
        tick_pair(1'b0, 1'b0);
        #7;
        check("R5 ddr q0 resume", q0[0], 1'b0);
        check("R5 ddr q2 resume", q2[0], 1'b0);
        #1;

        // R1: reset in the middle of traffic
        tick_pair(1'b1, 1'b1);
        tick_pair(1'b1, 1'b1);
        clk_pol = 1'b1;
        #1 rst = 1'b1;
        #7;
        tick_pair(1'b1, 1'b1);
        tick_pair(1'b1, 1'b1);
        #7;
        check("R1 q0 mid reset", q0[0], 1'b0);
        check("R1 q2 mid reset", q2[0], 1'b0);
        #1 rst = 1'b0;
        #7;

        // R2: single-data-rate capture, both polarities
        mode_ddr = 1'b0;
        for (int p = 0; p < 2; p++) begin
            clk_pol = p[0];
            for (int k = 0; k < 4; k++) begin
                logic bv;
                bv = k[0] ^ p[0];
                #1 din = bv;
                #6;
                check("R2 sdr q0", q0[0], bv);
                check("R2 sdr q2 zero", q2[0], 1'b0);
                #1;
            end
        end

        // R5: single-data-rate hold
        #1 din = 1'b1;
        #7;
        #1 ce = 1'b0;
        din = 1'b0;
        #6;
        check("R5 sdr hold", q0[0], 1'b1);
        #8;
        check("R5 sdr hold late", q0[0], 1'b1);
        #1 ce = 1'b1;

        // R6: bypass outputs follow the pin in both modes
        for (int m = 0; m < 2; m++) begin
            mode_ddr = m[0];
            din = 1'b1;
            #1;
            check("R6 raw_data high", raw_data[0], 1'b1);
            check("R6 raw_clk high", raw_clk[0], 1'b1);
            din = 1'b0;
            #1;
            check("R6 raw_data low", raw_data[0], 1'b0);
            check("R6 raw_clk low", raw_clk[0], 1'b0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule